// File: doc/BRIEF.md
# Lockstep Output Comparator

Two processors run the same program, one of them two cycles behind the other. This block compares their output buses bit for bit on every cycle and reports any difference. The leading processor's bus passes through a register pipeline inside the block. Each leading value therefore meets the trailing processor's value for the same program step, and the trailing bus is used as it arrives. A difference produces a registered one-cycle error pulse for an external error handler. It also sets a sticky status bit, which stays set until reset or an explicit clear.

Two maintenance modes exercise the comparator itself. The self-test sequencer is started by a pulse. It takes over both comparator inputs and applies a fixed series of equal and unequal patterns, and checks that each one is classified correctly. While it runs, the normal error outputs stay quiet. At the end it reports a pass or fail result. The error-forcing request flips one bit of the delayed leading value for one cycle. This produces exactly one error pulse, so the path to the error handler can be proven. The block then returns to plain comparison without further action.

Top module: `lockstep_cmp`

## Requirements
- R1: While the pipeline is full and no self-test runs, `cmp_err` is high in the cycle after a clock edge exactly when the `trail_bus` value sampled at that edge differs from the `lead_bus` value sampled two edges earlier. An aligned stream never errors, and an unaligned stream (lag 0) does.
- R2: A difference in any single bit position of the bus, including the lowest bit, the highest bit (BUS_W-1) and bits between them, raises `cmp_err`.
- R3: After reset is released, the first two clock edges load the pipeline and report no error, whatever the bus values are.
- R4: `err_sticky` is set by the same edge that raises `cmp_err`. It stays set until an edge with `err_clear` high and no new error. A new error at the same edge as a clear leaves it set.
- R5: A rising edge on `force_req` inverts bit FORCE_BIT (default 0) of the delayed leading value for exactly the next cycle, which gives one `cmp_err` pulse on matching streams. Holding `force_req` high gives only one pulse.
- R6: A force request is ignored while the pipeline is not yet full, while self-test is busy, and in the cycle that `selftest_start` is sampled.
- R7: `selftest_start`, sampled while idle, holds `st_busy` high for BUS_W+3 cycles. During that time the comparator checks all-zero and all-one equal pairs, then one unequal pair for each bit position. `cmp_err` and `err_sticky` are not changed by the bus inputs during a run.
- R8: At the end of a run `st_done` goes high and `st_pass` shows whether every pattern was classified correctly. Both hold until the next accepted start, which clears them. A start while busy is ignored.
- R9: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lead_bus | input | BUS_W | Output bus of the leading processor |
| trail_bus | input | BUS_W | Output bus of the trailing processor |
| selftest_start | input | 1 | Pulse that starts a self-test run |
| force_req | input | 1 | Request to inject one forced mismatch (rising edge) |
| err_clear | input | 1 | Clears the sticky error bit |
| cmp_err | output | 1 | Registered compare-error pulse |
| err_sticky | output | 1 | Sticky record of any reported error |
| st_busy | output | 1 | Self-test running |
| st_done | output | 1 | Self-test finished |
| st_pass | output | 1 | Self-test result, valid with st_done |

## Verification
The assertions assume that `selftest_start` and `force_req` are synchronous pulses or levels, and that the trailing bus is not required to match during self-test or before the pipeline fills. The self-test pass assertion also assumes that no hardware fault is present. The stimulus uses random buses and derives the trailing bus from the bench's own record of leading values two samples back. It inserts single-bit errors at chosen lanes. It keeps the trailing bus deliberately wrong during self-test and right after reset, so that suppression is tested under real mismatches.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } lsc_st_e;

    // Number of equal patterns applied before the per-lane unequal patterns.
    localparam int unsigned EQ_STEPS = 2;

    function automatic logic step_is_unequal(input logic [31:0] step);
        return step >= 32'(EQ_STEPS);
    endfunction

endpackage

// File: rtl/lsc_delay_line.sv
module lsc_delay_line #(
    parameter int unsigned WIDTH = 900,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             full
);
    localparam int unsigned FILL_W = $clog2(DEPTH + 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] stage;
        logic [FILL_W-1:0]           fill;
    } dl_regs_t;

    dl_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        nxt_d.stage[0] = din;
        for (int i = 1; i < int'(DEPTH); i++) begin
            nxt_d.stage[i] = cur_q.stage[i-1];
        end
        if (cur_q.fill != FILL_MAX) begin
            nxt_d.fill = cur_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dout = cur_q.stage[DEPTH-1];
    assign full = (cur_q.fill == FILL_MAX);

    // Once full, the pipeline stays full until reset.
    assert_fill_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> full);

endmodule

// File: rtl/lsc_compare.sv
module lsc_compare #(
    parameter int unsigned WIDTH = 900,
    parameter int unsigned CHUNK = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             report_i,
    output logic             hit_o,
    output logic             mism_o,
    output logic             err_o
);
    localparam int unsigned NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;
    localparam int unsigned PADW   = NCHUNK * CHUNK;

    typedef struct packed {
        logic mism;
        logic err;
    } cmp_regs_t;

    cmp_regs_t cur_q, nxt_d;

    logic [PADW-1:0]   diff_pad;
    logic [NCHUNK-1:0] chunk_hit;

    assign diff_pad = PADW'(op_a ^ op_b);

    for (genvar g = 0; g < int'(NCHUNK); g++) begin : g_chunk
        assign chunk_hit[g] = |diff_pad[g*CHUNK +: CHUNK];
    end

    assign hit_o = |chunk_hit;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.mism = hit_o;
        nxt_d.err  = hit_o & report_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mism_o = cur_q.mism;
    assign err_o  = cur_q.err;

    // A reported error only follows a cycle in which reporting was enabled.
    assert_err_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(report_i));

endmodule

// File: rtl/lsc_selftest.sv
module lsc_selftest
    import lsc_pkg::*;
#(
    parameter int unsigned WIDTH = 900
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mism_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic [WIDTH-1:0] pat_a_o,
    output logic [WIDTH-1:0] pat_b_o
);
    localparam int unsigned NSTEP  = WIDTH + EQ_STEPS;
    localparam int unsigned STEP_W = $clog2(NSTEP + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);
    localparam logic [WIDTH-1:0]  ONE_LSB   = WIDTH'(1);

    typedef struct packed {
        lsc_st_e           st;
        logic [STEP_W-1:0] step;
        logic              pend;
        logic              want;
        logic              fail;
        logic              done;
        logic              pass;
    } st_regs_t;

    st_regs_t cur_q, nxt_d;

    logic              bad;
    logic [STEP_W-1:0] lane;
    logic [WIDTH-1:0]  onehot;

    // Pattern generation from the current step.
    always_comb begin
        lane    = cur_q.step - STEP_W'(EQ_STEPS);
        onehot  = ONE_LSB << lane;
        pat_a_o = '0;
        pat_b_o = '0;
        if (cur_q.st == ST_RUN) begin
            if (cur_q.step == STEP_W'(0)) begin
                pat_a_o = '0;
                pat_b_o = '0;
            end else if (cur_q.step == STEP_W'(1)) begin
                pat_a_o = '1;
                pat_b_o = '1;
            end else if (!lane[0]) begin
                pat_a_o = '0;
                pat_b_o = onehot;
            end else begin
                pat_a_o = ~onehot;
                pat_b_o = '1;
            end
        end
    end

    // Sequencer and result checking (one-cycle lag behind the patterns).
    always_comb begin
        nxt_d = cur_q;
        bad   = cur_q.pend && (mism_i != cur_q.want);
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.st   = ST_RUN;
                    nxt_d.step = '0;
                    nxt_d.pend = 1'b0;
                    nxt_d.fail = 1'b0;
                    nxt_d.done = 1'b0;
                    nxt_d.pass = 1'b0;
                end
            end
            ST_RUN: begin
                nxt_d.fail = cur_q.fail | bad;
                nxt_d.pend = 1'b1;
                nxt_d.want = step_is_unequal(32'(cur_q.step));
                if (cur_q.step == LAST_STEP) begin
                    nxt_d.st = ST_DRAIN;
                end else begin
                    nxt_d.step = cur_q.step + 1'b1;
                end
            end
            ST_DRAIN: begin
                nxt_d.fail = cur_q.fail | bad;
                nxt_d.pend = 1'b0;
                nxt_d.st   = ST_IDLE;
                nxt_d.done = 1'b1;
                nxt_d.pass = !(cur_q.fail | bad);
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_o = (cur_q.st != ST_IDLE);
    assign done_o = cur_q.done;
    assign pass_o = cur_q.pass;

    // Done and busy never overlap.
    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // A fault-free comparator always passes its own test.
    assert_pass_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> pass_o);

    // The step counter never runs past the last pattern.
    assert_step_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_RUN) |-> (cur_q.step <= LAST_STEP));

endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp #(
    parameter int unsigned BUS_W     = 900,
    parameter int unsigned LAG       = 2,
    parameter int unsigned FORCE_BIT = 0,
    parameter int unsigned CHUNK     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] lead_bus,
    input  logic [BUS_W-1:0] trail_bus,
    input  logic             selftest_start,
    input  logic             force_req,
    input  logic             err_clear,
    output logic             cmp_err,
    output logic             err_sticky,
    output logic             st_busy,
    output logic             st_done,
    output logic             st_pass
);
    localparam logic [BUS_W-1:0] FORCE_MASK = BUS_W'(1) << FORCE_BIT;

    typedef struct packed {
        logic force_on;
        logic req_prev;
        logic sticky;
    } top_regs_t;

    top_regs_t cur_q, nxt_d;

    logic [BUS_W-1:0] lead_dly;
    logic             armed;
    logic             st_busy_w;
    logic [BUS_W-1:0] pat_a;
    logic [BUS_W-1:0] pat_b;
    logic [BUS_W-1:0] op_a;
    logic [BUS_W-1:0] op_b;
    logic             report;
    logic             hit;
    logic             mism_raw;
    logic             err_reg;

    lsc_delay_line #(
        .WIDTH (BUS_W),
        .DEPTH (LAG)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (lead_bus),
        .dout  (lead_dly),
        .full  (armed)
    );

    lsc_selftest #(
        .WIDTH (BUS_W)
    ) u_selftest (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (selftest_start),
        .mism_i  (mism_raw),
        .busy_o  (st_busy_w),
        .done_o  (st_done),
        .pass_o  (st_pass),
        .pat_a_o (pat_a),
        .pat_b_o (pat_b)
    );

    // Operand selection: self-test patterns, or delayed lead (optionally
    // with one bit flipped) against the live trailing bus.
    always_comb begin
        if (st_busy_w) begin
            op_a = pat_a;
            op_b = pat_b;
        end else begin
            op_a = lead_dly ^ (cur_q.force_on ? FORCE_MASK : '0);
            op_b = trail_bus;
        end
        report = armed & ~st_busy_w;
    end

    lsc_compare #(
        .WIDTH (BUS_W),
        .CHUNK (CHUNK)
    ) u_compare (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_a     (op_a),
        .op_b     (op_b),
        .report_i (report),
        .hit_o    (hit),
        .mism_o   (mism_raw),
        .err_o    (err_reg)
    );

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.req_prev = force_req;
        nxt_d.force_on = force_req & ~cur_q.req_prev & armed
                         & ~st_busy_w & ~selftest_start;
        nxt_d.sticky   = (cur_q.sticky & ~err_clear) | (hit & report);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cmp_err    = err_reg;
    assign err_sticky = cur_q.sticky;
    assign st_busy    = st_busy_w;

    // No error is reported from a cycle in which the pipeline was not full.
    assert_no_early_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(armed) |-> !cmp_err);

    // Self-test cycles never leak onto the error output.
    assert_quiet_selftest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_busy_w) |-> !cmp_err);

    // Every error pulse is recorded in the sticky bit.
    assert_sticky_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_err |-> err_sticky);

    // Forcing lasts a single cycle.
    assert_force_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.force_on |=> !cur_q.force_on);

    // Forcing never coincides with a self-test run.
    assert_force_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.force_on |-> !st_busy_w);

endmodule

// File: tb/lockstep_cmp_test.sv
`timescale 1ns/1ps
module lockstep_cmp_test;
    localparam int W     = 900;
    localparam int NSTEP = W + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] lead_bus = '0;
    logic [W-1:0] trail_bus = '0;
    logic         selftest_start = 1'b0;
    logic         force_req = 1'b0;
    logic         err_clear = 1'b0;
    logic         cmp_err, err_sticky, st_busy, st_done, st_pass;

    always #5 clk = ~clk;

    lockstep_cmp uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .lead_bus       (lead_bus),
        .trail_bus      (trail_bus),
        .selftest_start (selftest_start),
        .force_req      (force_req),
        .err_clear      (err_clear),
        .cmp_err        (cmp_err),
        .err_sticky     (err_sticky),
        .st_busy        (st_busy),
        .st_done        (st_done),
        .st_pass        (st_pass)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R9";

    // Behavioural reference: queue of leading samples, counters, flags.
    logic [W-1:0] mq[$];
    logic [W-1:0] hist[$];
    bit m_req, m_force, m_err, m_sticky, m_done, m_pass;
    int m_busy;

    task automatic check1(input string nm, input logic got, input logic want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s %s got %0b expected %0b", tag, nm, got, want);
        end
    endtask

    task automatic check_all();
        check1("cmp_err", cmp_err, m_err);
        check1("err_sticky", err_sticky, m_sticky);
        check1("st_busy", st_busy, m_busy > 0);
        check1("st_done", st_done, m_done);
        check1("st_pass", st_pass, m_pass);
    endtask

    task automatic model_reset();
        mq.delete();
        hist.delete();
        m_req = 0; m_force = 0; m_err = 0; m_sticky = 0;
        m_done = 0; m_pass = 0; m_busy = 0;
    endtask

    task automatic model_step(input logic [W-1:0] ld, input logic [W-1:0] tr,
                              input bit st, input bit fr, input bit cl);
        bit           armed;
        bit           busy;
        bit           e;
        logic [W-1:0] opa;
        armed = (mq.size() == 2);
        busy  = (m_busy > 0);
        opa   = armed ? mq[0] : '0;
        if (m_force) opa[0] = ~opa[0];
        e        = armed && !busy && (opa != tr);
        m_err    = e;
        m_sticky = (m_sticky && !cl) || e;
        m_force  = fr && !m_req && armed && !busy && !st;
        m_req    = fr;
        if (busy) begin
            m_busy--;
            if (m_busy == 0) begin
                m_done = 1; m_pass = 1;
            end
        end else if (st) begin
            m_busy = NSTEP + 1; m_done = 0; m_pass = 0;
        end
        mq.push_back(ld);
        if (mq.size() > 2) void'(mq.pop_front());
    endtask

    function automatic logic [W-1:0] rnd();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = 1'($urandom_range(0, 1));
        return v;
    endfunction

    function automatic logic [W-1:0] aligned();
        if (hist.size() >= 2) return hist[$-1];
        return rnd();
    endfunction

    task automatic cyc(input logic [W-1:0] ld, input logic [W-1:0] tr,
                       input bit st, input bit fr, input bit cl);
        @(negedge clk);
        check_all();
        lead_bus = ld; trail_bus = tr;
        selftest_start = st; force_req = fr; err_clear = cl;
        model_step(ld, tr, st, fr, cl);
        hist.push_back(ld);
    endtask

    task automatic eq(input int n);
        for (int i = 0; i < n; i++) cyc(rnd(), aligned(), 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lead_bus = '0; trail_bus = '0;
        selftest_start = 0; force_req = 0; err_clear = 0;
        model_reset();
        tag = "R9";
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check_all();
        end
        rst_n = 1'b1;
        model_step('0, '0, 0, 0, 0);
        hist.push_back('0);
    endtask

    initial begin
        logic [W-1:0] t;
        int lanes[4];
        do_reset();

        // R3: mismatching buses while the pipeline loads
        tag = "R3";
        cyc(rnd(), rnd(), 0, 0, 0);
        cyc(rnd(), aligned(), 0, 0, 0);

        // R1: aligned stream, then an unaligned (lag 0) stream
        tag = "R1";
        eq(40);
        for (int i = 0; i < 3; i++) begin
            t = rnd();
            cyc(t, t, 0, 0, 0);
        end
        eq(4);

        // R2: single-lane corruption at low, middle, high and odd lanes
        tag = "R2";
        lanes = '{0, W/2, W-1, 37};
        foreach (lanes[k]) begin
            t = aligned();
            t[lanes[k]] = ~t[lanes[k]];
            cyc(rnd(), t, 0, 0, 0);
            eq(2);
        end

        // R4: clear, then clear together with a new error
        tag = "R4";
        cyc(rnd(), aligned(), 0, 0, 1);
        eq(2);
        t = aligned(); t[5] = ~t[5];
        cyc(rnd(), t, 0, 0, 1);
        eq(2);
        cyc(rnd(), aligned(), 0, 0, 1);
        eq(2);

        // R5: single force pulse, then a force request held high
        tag = "R5";
        cyc(rnd(), aligned(), 0, 1, 0);
        eq(4);
        for (int i = 0; i < 5; i++) cyc(rnd(), aligned(), 0, 1, 0);
        eq(4);
        cyc(rnd(), aligned(), 0, 0, 1);
        eq(2);

        // R6: force before the pipeline fills, and together with start
        do_reset();
        tag = "R6";
        cyc(rnd(), rnd(), 0, 1, 0);
        cyc(rnd(), aligned(), 0, 0, 0);
        eq(3);
        cyc(rnd(), aligned(), 1, 1, 0);

        // R7: self-test runs under wrong trailing data; force is ignored
        tag = "R7";
        for (int i = 0; i < NSTEP + 1; i++) begin
            if (i == 100) tag = "R8";
            if (i == 200) tag = "R6";
            cyc(rnd(), rnd(), i == 100, i == 200, 0);
            tag = (i >= 100) ? "R8" : "R7";
        end

        // R8: result held, normal compare resumes, second run from idle
        tag = "R8";
        eq(6);
        cyc(rnd(), aligned(), 0, 0, 1);
        cyc(rnd(), aligned(), 1, 0, 0);
        for (int i = 0; i < NSTEP + 1; i++) cyc(rnd(), aligned(), 0, 0, 0);
        eq(4);

        @(negedge clk);
        check_all();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule